// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A command supplies a start column and a direction. The block reads the burst length, the wrap order and the single-write option from a mode image at that moment. From the next clock on it presents one column per cycle, with a valid flag, a last-beat flag and the direction of the burst.

Bursts of 1, 2, 4 or 8 beats wrap inside an aligned group of that size, in either sequential or interleaved order. A full-page burst runs sequentially along the whole row. It wraps from the top column back to column 0 and only stops when terminated. The mode image is captured only when a command is accepted, so the mode pins may change freely during a burst. A new command during a burst replaces the running one. A terminate input ends any burst early. The column width is a parameter, and a full page covers all 2^COL_W columns.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and after it is released with no command given, col_valid and col_last are low.
- R2: A command accepted on a clock edge makes col_valid high after that edge, with col_addr equal to the start column and col_write equal to the command's write bit.
- R3: Length field encoding of mode_bl: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page. A command issued under codes 3'b100 to 3'b110 is dropped, and any burst in progress continues unchanged.
- R4: With mode_ilv = 0 and length L of 2, 4 or 8, beat n carries (start & ~(L-1)) | ((start + n) & (L-1)).
- R5: With mode_ilv = 1 and length L of 1, 2, 4 or 8, beat n carries start ^ (n & (L-1)).
- R6: A full-page burst carries (start + n) mod 2^COL_W on beat n, passes from the top column to column 0, runs until terminated, and never raises col_last.
- R7: Full page combined with mode_ilv = 1 is illegal. Such a command is dropped, and any burst in progress continues unchanged.
- R8: For a fixed-length burst, col_last is high exactly on the final beat. If no command is accepted on that edge, col_valid is low in the next cycle.
- R9: With mode_wr_single = 1, a write command gives a single beat with col_last high. Read commands still use the programmed length.
- R10: If term is high on an edge with no accepted command, col_valid is low after that edge. If a command is accepted on the same edge, the command takes priority.
- R11: A command accepted during a burst restarts the sequence from its own start column under the mode present at that edge.
- R12: Changes on mode_bl, mode_ilv or mode_wr_single while a burst runs do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_bl | input | 3 | Burst length code from mode image |
| mode_ilv | input | 1 | Wrap order: 0 sequential, 1 interleave |
| mode_wr_single | input | 1 | 1: writes are single beat |
| cmd_valid | input | 1 | Read or write command this cycle |
| cmd_write | input | 1 | 1: write, 0: read |
| cmd_col | input | COL_W | Start column of the command |
| term | input | 1 | Terminate the running burst |
| col_valid | output | 1 | A burst beat is presented |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| col_write | output | 1 | Direction of the current burst |

## Verification
The bench targets start columns in the middle of an aligned group, where a design that carries into the upper bits, or that mixes up sequential and interleaved order, leaves the group or visits the wrong columns. It runs a full-page burst across the top of the row, which catches a design that stops or raises col_last there. It mixes illegal and reserved length codes, the single-write option, term together with a command, and mode changes during a burst. A design that gets these wrong would drop a running burst, shorten reads, ignore the priority of a command, or take up the new mode halfway through a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam logic [2:0] BL_CODE_1    = 3'b000;
    localparam logic [2:0] BL_CODE_2    = 3'b001;
    localparam logic [2:0] BL_CODE_4    = 3'b010;
    localparam logic [2:0] BL_CODE_8    = 3'b011;
    localparam logic [2:0] BL_CODE_PAGE = 3'b111;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_ILV = 1'b1
    } wrap_e;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       bl_code,
    input  wrap_e            wrap,
    input  logic             wr_single,
    input  logic             is_write,
    output logic             legal,
    output logic             full_page,
    output logic [COL_W-1:0] low_mask
);

    always_comb begin
        legal     = 1'b1;
        full_page = 1'b0;
        low_mask  = '0;
        case (bl_code)
            BL_CODE_1:    low_mask = '0;
            BL_CODE_2:    low_mask = COL_W'(1);
            BL_CODE_4:    low_mask = COL_W'(3);
            BL_CODE_8:    low_mask = COL_W'(7);
            BL_CODE_PAGE: begin
                full_page = 1'b1;
                low_mask  = '1;
                legal     = (wrap == WRAP_SEQ);
            end
            default:      legal = 1'b0;
        endcase
        if (wr_single && is_write) begin
            full_page = 1'b0;
            low_mask  = '0;
        end
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] low_mask,
    input  wrap_e            wrap,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] ilv_addr;

    always_comb begin
        seq_addr = (start_col & ~low_mask) | ((start_col + beat_idx) & low_mask);
        ilv_addr = start_col ^ (beat_idx & low_mask);
        addr     = (wrap == WRAP_ILV) ? ilv_addr : seq_addr;
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_bl,
    input  logic             mode_ilv,
    input  logic             mode_wr_single,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             term,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             col_write
);

    typedef struct packed {
        logic             active;
        logic             write;
        wrap_e            wrap;
        logic             full;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] beat;
    } state_t;

    state_t st_d, st_q;

    logic             cmd_legal;
    logic             cmd_full;
    logic [COL_W-1:0] cmd_mask;
    logic             at_last;

    burst_mode_decode #(.COL_W(COL_W)) u_decode (
        .bl_code   (mode_bl),
        .wrap      (wrap_e'(mode_ilv)),
        .wr_single (mode_wr_single),
        .is_write  (cmd_write),
        .legal     (cmd_legal),
        .full_page (cmd_full),
        .low_mask  (cmd_mask)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_addr (
        .start_col (st_q.start),
        .beat_idx  (st_q.beat),
        .low_mask  (st_q.mask),
        .wrap      (st_q.wrap),
        .addr      (col_addr)
    );

    assign at_last = st_q.active && !st_q.full && (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (cmd_valid && cmd_legal) begin
            st_d.active = 1'b1;
            st_d.write  = cmd_write;
            st_d.wrap   = wrap_e'(mode_ilv);
            st_d.full   = cmd_full;
            st_d.mask   = cmd_mask;
            st_d.start  = cmd_col;
            st_d.beat   = '0;
        end else if (st_q.active) begin
            if (term || at_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_valid = st_q.active;
    assign col_last  = at_last;
    assign col_write = st_q.write;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker
    import burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_bl,
    input logic             mode_ilv,
    input logic             cmd_valid,
    input logic             term,
    input logic             col_valid,
    input logic             col_last,
    input logic             col_write
);

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R8

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid); // R8

    AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !term) |=> col_valid); // R6

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd_valid) |=> !col_valid); // R10

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !cmd_valid) |=> (!col_valid || $stable(col_write))); // R12

    AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !col_valid && mode_bl == BL_CODE_PAGE && mode_ilv) |=> !col_valid); // R7

    AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !col_valid && mode_bl[2] && mode_bl != BL_CODE_PAGE) |=> !col_valid); // R3

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_colgen_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_bl   (mode_bl),
    .mode_ilv  (mode_ilv),
    .cmd_valid (cmd_valid),
    .term      (term),
    .col_valid (col_valid),
    .col_last  (col_last),
    .col_write (col_write)
);

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;

    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [2:0]       mode_bl;
    logic             mode_ilv;
    logic             mode_wr_single;
    logic             cmd_valid;
    logic             cmd_write;
    logic [COL_W-1:0] cmd_col;
    logic             term;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             col_last;
    logic             col_write;

    int n_checks = 0;
    int n_fails  = 0;

    // expected-behaviour state
    logic m_active = 1'b0;
    int   m_start, m_n, m_len;
    logic m_ilv, m_write;

    always #2.5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) dut (
        .clk, .rst_n, .mode_bl, .mode_ilv, .mode_wr_single,
        .cmd_valid, .cmd_write, .cmd_col, .term,
        .col_valid, .col_addr, .col_last, .col_write
    );

    function automatic int code_len(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic int exp_addr(input int s, input int n, input int len, input logic ilv);
        int msk;
        if (len == 0) return (s + n) % NCOL;
        msk = len - 1;
        if (ilv) return s ^ (n & msk);
        return (s & ~msk) | ((s + n) & msk);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cycle(input string req, input logic cv, input logic cw, input int col,
                         input logic trm, input logic [2:0] bl, input logic ilv, input logic ws);
        int  len;
        logic legal;
        cmd_valid = cv; cmd_write = cw; cmd_col = COL_W'(col); term = trm;
        mode_bl = bl; mode_ilv = ilv; mode_wr_single = ws;
        @(posedge clk);
        len   = code_len(bl);
        legal = (len >= 0) && !(len == 0 && ilv);
        if (cv && legal) begin
            m_active = 1'b1; m_start = col; m_n = 0; m_ilv = ilv; m_write = cw;
            m_len = (ws && cw) ? 1 : len;
        end else if (m_active) begin
            if (trm || (m_len != 0 && m_n == m_len - 1)) m_active = 1'b0;
            else m_n = (m_n + 1) % NCOL;
        end
        @(negedge clk);
        check(req, "col_valid", int'(col_valid), int'(m_active));
        check(req, "col_last", int'(col_last),
              int'(m_active && m_len != 0 && m_n == m_len - 1));
        if (m_active) begin
            check(req, "col_addr", int'(col_addr), exp_addr(m_start, m_n, m_len, m_ilv));
            check(req, "col_write", int'(col_write), int'(m_write));
        end
    endtask

    task automatic idle(input string req, input int k, input logic [2:0] bl, input logic ilv);
        for (int i = 0; i < k; i++) cycle(req, 1'b0, 1'b0, 0, 1'b0, bl, ilv, 1'b0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        rst_n = 1'b0; cmd_valid = 0; cmd_write = 0; cmd_col = '0; term = 0;
        mode_bl = 3'b010; mode_ilv = 0; mode_wr_single = 0;
        repeat (3) @(negedge clk);
        check("R1", "col_valid in reset", int'(col_valid), 0);
        check("R1", "col_last in reset", int'(col_last), 0);
        rst_n = 1'b1;
        idle("R1", 2, 3'b010, 1'b0);

        // R2/R4: BL4 sequential, start mid-group
        cycle("R2", 1, 0, 6, 0, 3'b010, 0, 0);
        idle("R4", 4, 3'b010, 0);
        // R4: BL8 sequential
        cycle("R4", 1, 1, 21, 0, 3'b011, 0, 0);
        idle("R4", 8, 3'b011, 0);
        // R5: BL8 interleave, BL2 interleave
        cycle("R5", 1, 0, 13, 0, 3'b011, 1, 0);
        idle("R5", 8, 3'b011, 1);
        cycle("R5", 1, 0, 7, 0, 3'b001, 1, 0);
        idle("R5", 3, 3'b001, 1);
        // R8: BL1
        cycle("R8", 1, 0, 99, 0, 3'b000, 0, 0);
        idle("R8", 2, 3'b000, 0);
        // R6: full page across the top of the row and a whole lap, then term (R10)
        cycle("R6", 1, 0, 500, 0, 3'b111, 0, 0);
        idle("R6", NCOL + 20, 3'b111, 0);
        cycle("R10", 0, 0, 0, 1, 3'b111, 0, 0);
        idle("R10", 2, 3'b111, 0);
        // R7: illegal full+interleave during BL8 burst
        cycle("R7", 1, 0, 40, 0, 3'b011, 0, 0);
        cycle("R7", 1, 1, 300, 0, 3'b111, 1, 0);
        idle("R7", 8, 3'b011, 0);
        // R3: reserved code dropped, during and outside burst
        cycle("R3", 1, 0, 17, 0, 3'b101, 0, 0);
        cycle("R3", 1, 0, 64, 0, 3'b010, 0, 0);
        cycle("R3", 1, 1, 9, 0, 3'b110, 0, 0);
        idle("R3", 4, 3'b100, 0);
        // R9: single-beat write, read still bursts
        cycle("R9", 1, 1, 35, 0, 3'b011, 0, 1);
        idle("R9", 2, 3'b011, 0);
        cycle("R9", 1, 0, 35, 0, 3'b011, 0, 1);
        idle("R9", 8, 3'b011, 0);
        // R10: term with command, command wins
        cycle("R10", 1, 0, 80, 0, 3'b011, 0, 0);
        cycle("R10", 1, 1, 130, 1, 3'b010, 1, 0);
        idle("R10", 5, 3'b010, 1);
        // R11: restart mid-burst
        cycle("R11", 1, 0, 200, 0, 3'b011, 0, 0);
        idle("R11", 2, 3'b011, 0);
        cycle("R11", 1, 0, 255, 0, 3'b010, 0, 0);
        idle("R11", 5, 3'b010, 0);
        // R12: mode churn during a burst
        cycle("R12", 1, 0, 66, 0, 3'b011, 1, 0);
        for (int i = 0; i < 9; i++)
            cycle("R12", 0, 0, 0, 0, 3'(i), ~i[0], i[1]);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] bl;
            int r;
            r  = $urandom % 16;
            bl = (r < 3) ? 3'b111 : (r == 3) ? 3'b101 : 3'(r % 4);
            cycle("R8", ($urandom % 6) == 0, $urandom % 2, $urandom % NCOL,
                  ($urandom % 24) == 0, bl, ($urandom % 3) == 0, ($urandom % 4) == 0);
        end
        finish_run();
    end

endmodule